// File: doc/BRIEF.md
# Flippable Four-Plane Pixel Shifter

This block turns parallel bit-plane bytes into serial pixel streams for a character-cell display. Four planes run side by side. Two carry shape imagery held in RAM and two carry character imagery held in ROM. Every plane emits one pixel bit per clock. When the load strobe is high, all planes capture a fresh byte together. Otherwise they shift one position per clock and fill with zeros, so a plane that has not been reloaded shows transparent pixels.

For a table-top cabinet the picture must be shown rotated by 180 degrees. Each plane therefore keeps two registers. One holds the byte as it arrives. The other holds it with its bit order reversed. A flip input picks which of the two drives the plane's output.

The same flip input also conditions the fetch addresses. The block takes a raw 10-bit cell address and a 3-bit scanline-in-cell count. In flip mode it inverts every bit of both. It then adds one, wrapping modulo 8, to the three most significant bits of the inverted cell address. The result mirrors the fetch pattern both vertically and horizontally.

Top module: `plane_shifter`

## Requirements
- R1: While `rstN` is low, every serial output is 0, even if the load strobe is high and the plane bytes are nonzero.
- R2: When `loadIn` is high at a clock edge, all four planes capture their bytes together. Plane p takes `planeBytes[8p+7:8p]`, with plane 0 = shape 1, plane 1 = shape 2, plane 2 = character 1 and plane 3 = character 2. The first pixel of each byte is on `serOut[p]` in the cycle that follows the load, for both flip settings.
- R3: With `flip` low, a loaded byte leaves MSB first: bit 7, then bit 6, down to bit 0 in the eighth cycle after the load.
- R4: With `flip` high, a loaded byte leaves LSB first: bit 0, then bit 1, up to bit 7 in the eighth cycle after the load.
- R5: `flip` selects per cycle between the two registers of each plane. In cycle k after a load (k = 0..7), `serOut[p]` is bit 7-k when `flip` is low and bit k when `flip` is high, even when `flip` changes in the middle of a byte.
- R6: From the ninth cycle after the last load onward, and after reset until the first load, every serial output is 0.
- R7: A load takes effect at any clock, including when the previous byte has not fully shifted out. The new byte replaces the old one and its first pixel follows in the next cycle.
- R8: With `flip` low, `cellAddrOut` equals `cellAddrIn` and `lineOut` equals `lineIn`. Column is bits 4:0 and row is bits 9:5.
- R9: With `flip` high, `cellAddrOut[6:0]` is the bitwise inverse of `cellAddrIn[6:0]`. `cellAddrOut[9:7]` is the inverse of `cellAddrIn[9:7]` plus 1, modulo 8.
- R10: With `flip` high, `lineOut` is the bitwise inverse of `lineIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadIn | input | 1 | Parallel load strobe, normally high once every 8 clocks |
| flip | input | 1 | Table-top flip: selects the reversed path and inverts addresses |
| planeBytes | input | 32 | Four plane bytes, plane p at bits 8p+7:8p |
| serOut | output | 4 | One serial pixel bit per plane |
| cellAddrIn | input | 10 | Raw cell address, row in 9:5 and column in 4:0 |
| lineIn | input | 3 | Raw scanline number inside the cell |
| cellAddrOut | output | 10 | Cell address after flip conditioning |
| lineOut | output | 3 | Scanline number after flip conditioning |

## Verification
The bench builds the block with its default widths: four planes of 8 bits, a 5 by 5 cell address, a 3-bit line count and a 3-bit adjusted field. With 8-bit planes, a byte drains within a few cycles. That makes it cheap to cover the zero-fill tail, reloads in the middle of a byte, and `flip` toggling every cycle. The 3-bit adjusted field makes the wrap from 111 to 000 reachable with a single address value.

// File: rtl/plane_shifter_pkg.sv
package plane_shifter_pkg;

  // Strobes the control half hands to the shift datapath each cycle.
  typedef struct packed {
    logic load;    // capture all plane bytes
    logic shift;   // advance every register by one pixel
    logic selRev;  // drive outputs from the bit-reversed registers
  } shiftCtl_t;

endpackage

// File: rtl/plane_shifter_ctl.sv
module plane_shifter_ctl
  import plane_shifter_pkg::*;
#(
  parameter int CELL_W = 10,
  parameter int LINE_W = 3,
  parameter int HI_W   = 3
) (
  input  logic              loadIn,
  input  logic              flip,
  input  logic [CELL_W-1:0] cellAddrIn,
  input  logic [LINE_W-1:0] lineIn,
  output shiftCtl_t         ctl,
  output logic [CELL_W-1:0] cellAddrOut,
  output logic [LINE_W-1:0] lineOut
);

  localparam int LO_W = CELL_W - HI_W;

  logic [CELL_W-1:0] invAddr;
  logic [HI_W-1:0]   hiAdj;

  always_comb begin
    ctl.load   = loadIn;
    ctl.shift  = !loadIn;
    ctl.selRev = flip;
  end

  // Inversion mirrors the fetch order; the carry into the top field
  // realigns the mirrored rows with the visible window.
  always_comb begin
    invAddr     = cellAddrIn ^ {CELL_W{flip}};
    hiAdj       = invAddr[CELL_W-1 -: HI_W] + HI_W'(flip);
    cellAddrOut = {hiAdj, invAddr[LO_W-1:0]};
    lineOut     = lineIn ^ {LINE_W{flip}};
  end

endmodule

// File: rtl/plane_shifter_dp.sv
module plane_shifter_dp
  import plane_shifter_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int PIX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  shiftCtl_t               ctl,
  input  logic [PLANES*PIX_W-1:0] planeBytes,
  output logic [PLANES-1:0]       serOut
);

  localparam int MSB = PIX_W - 1;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [PIX_W-1:0] inByte;
    logic [PIX_W-1:0] inRev;
    logic [PIX_W-1:0] normReg;
    logic [PIX_W-1:0] revReg;

    assign inByte = planeBytes[p*PIX_W +: PIX_W];

    for (genvar b = 0; b < PIX_W; b++) begin : g_rev
      assign inRev[b] = inByte[MSB-b];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        normReg <= '0;
        revReg  <= '0;
      end else if (ctl.load) begin
        normReg <= inByte;
        revReg  <= inRev;
      end else if (ctl.shift) begin
        normReg <= {normReg[MSB-1:0], 1'b0};
        revReg  <= {revReg[MSB-1:0], 1'b0};
      end
    end

    assign serOut[p] = ctl.selRev ? revReg[MSB] : normReg[MSB];
  end

endmodule

// File: rtl/plane_shifter.sv
module plane_shifter
  import plane_shifter_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int PIX_W  = 8,
  parameter int COL_W  = 5,
  parameter int ROW_W  = 5,
  parameter int LINE_W = 3,
  parameter int HI_W   = 3,
  localparam int CELL_W = COL_W + ROW_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loadIn,
  input  logic                    flip,
  input  logic [PLANES*PIX_W-1:0] planeBytes,
  output logic [PLANES-1:0]       serOut,
  input  logic [CELL_W-1:0]       cellAddrIn,
  input  logic [LINE_W-1:0]       lineIn,
  output logic [CELL_W-1:0]       cellAddrOut,
  output logic [LINE_W-1:0]       lineOut
);

  shiftCtl_t ctl;

  plane_shifter_ctl #(
    .CELL_W(CELL_W), .LINE_W(LINE_W), .HI_W(HI_W)
  ) i_ctl (
    .loadIn(loadIn), .flip(flip), .cellAddrIn(cellAddrIn), .lineIn(lineIn),
    .ctl(ctl), .cellAddrOut(cellAddrOut), .lineOut(lineOut)
  );

  plane_shifter_dp #(
    .PLANES(PLANES), .PIX_W(PIX_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .planeBytes(planeBytes), .serOut(serOut)
  );

endmodule

// File: rtl/plane_shifter_chk.sv
module plane_shifter_chk #(
  parameter int PLANES = 4,
  parameter int PIX_W  = 8,
  parameter int CELL_W = 10,
  parameter int LINE_W = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    loadIn,
  input logic                    flip,
  input logic [PLANES*PIX_W-1:0] planeBytes,
  input logic [PLANES-1:0]       serOut,
  input logic [CELL_W-1:0]       cellAddrIn,
  input logic [LINE_W-1:0]       lineIn,
  input logic [CELL_W-1:0]       cellAddrOut,
  input logic [LINE_W-1:0]       lineOut
);

  localparam int CNT_W = $clog2(PIX_W + 1) + 1;

  logic [PLANES-1:0] msbVec;
  logic [PLANES-1:0] lsbVec;
  logic [CNT_W-1:0]  sinceLoad;

  always_comb begin
    for (int p = 0; p < PLANES; p++) begin
      msbVec[p] = planeBytes[p*PIX_W + PIX_W - 1];
      lsbVec[p] = planeBytes[p*PIX_W];
    end
  end

  // Cycles since the last capture, saturating once a byte has drained.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceLoad <= CNT_W'(PIX_W);
    else if (loadIn) sinceLoad <= '0;
    else if (sinceLoad < CNT_W'(PIX_W)) sinceLoad <= sinceLoad + 1'b1;
  end

  p_quiet_reset_r1: assert property (@(posedge clk)
    !rstN |-> serOut == '0);

  p_first_pixel_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadIn && !flip |=> (!flip -> serOut == $past(msbVec)));

  p_first_pixel_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadIn && flip |=> (flip -> serOut == $past(lsbVec)));

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    sinceLoad >= CNT_W'(PIX_W) |-> serOut == '0);

  p_pass_noflip_r8: assert property (@(posedge clk) disable iff (!rstN)
    !flip |-> cellAddrOut == cellAddrIn && lineOut == lineIn);

endmodule

bind plane_shifter plane_shifter_chk #(
  .PLANES(PLANES), .PIX_W(PIX_W), .CELL_W(CELL_W), .LINE_W(LINE_W)
) i_chk (
  .clk(clk), .rstN(rstN), .loadIn(loadIn), .flip(flip),
  .planeBytes(planeBytes), .serOut(serOut), .cellAddrIn(cellAddrIn),
  .lineIn(lineIn), .cellAddrOut(cellAddrOut), .lineOut(lineOut)
);

// File: tb/test_plane_shifter.sv
module test_plane_shifter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadIn = 1'b0;
  logic        flip = 1'b0;
  logic [31:0] planeBytes = '0;
  logic [3:0]  serOut;
  logic [9:0]  cellAddrIn = '0;
  logic [2:0]  lineIn = '0;
  logic [9:0]  cellAddrOut;
  logic [2:0]  lineOut;

  int total = 0;
  int bad = 0;

  // Behavioural reference: last captured bytes and cycles since capture.
  logic [7:0]  mb [4];
  int          kPos = 8;
  logic [31:0] seed = 32'h1234_5678;
  bit          lastLoad = 1'b0;

  always #5 clk = ~clk;

  plane_shifter i_plane_shifter (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .flip(flip),
    .planeBytes(planeBytes), .serOut(serOut), .cellAddrIn(cellAddrIn),
    .lineIn(lineIn), .cellAddrOut(cellAddrOut), .lineOut(lineOut)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [3:0] expSer(input bit f);
    logic [3:0] e;
    for (int p = 0; p < 4; p++) begin
      if (kPos >= 8) e[p] = 1'b0;
      else if (f) e[p] = mb[p][kPos];
      else e[p] = mb[p][7 - kPos];
    end
    return e;
  endfunction

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s serOut actual=%b expected=%b (k=%0d flip=%b)", req, act, exp, kPos, flip);
    end
  endtask

  // Drive one pixel cycle from a negedge, then compare at the next negedge.
  task automatic step(input bit l, input bit f, input logic [31:0] b, input string tag);
    string req;
    loadIn = l;
    flip = f;
    planeBytes = b;
    @(posedge clk);
    if (l) begin
      for (int p = 0; p < 4; p++) mb[p] = b[p*8 +: 8];
      kPos = 0;
    end else if (kPos < 8) begin
      kPos++;
    end
    @(negedge clk);
    if (tag != "") req = tag;
    else if (kPos >= 8) req = "R6";
    else if (l) req = "R2";
    else if (f) req = "R4";
    else req = "R3";
    check4(req, serOut, expSer(f));
    lastLoad = l;
  endtask

  task automatic chkAddr(input logic [9:0] a, input logic [2:0] ln, input bit f);
    logic [9:0] inv;
    logic [9:0] expA;
    logic [2:0] expL;
    cellAddrIn = a;
    lineIn = ln;
    flip = f;
    #1;
    if (f) begin
      inv = ~a;
      expA = {inv[9:7] + 3'd1, inv[6:0]};
      expL = ~ln;
    end else begin
      expA = a;
      expL = ln;
    end
    total++;
    if (cellAddrOut !== expA) begin
      bad++;
      $display("FAIL %s cellAddrOut actual=%h expected=%h", f ? "R9" : "R8", cellAddrOut, expA);
    end
    total++;
    if (lineOut !== expL) begin
      bad++;
      $display("FAIL %s lineOut actual=%h expected=%h", f ? "R10" : "R8", lineOut, expL);
    end
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) mb[p] = 8'h00;

    // R1: outputs stay zero in reset even with a load request.
    loadIn = 1'b1;
    planeBytes = 32'hFFFF_FFFF;
    @(negedge clk);
    check4("R1", serOut, 4'b0000);
    @(negedge clk);
    check4("R1", serOut, 4'b0000);
    loadIn = 1'b0;

    // R8, R9, R10: address conditioning, including the top-field wrap.
    chkAddr(10'h000, 3'd0, 1'b0);
    chkAddr(10'h2B5, 3'd5, 1'b0);
    chkAddr(10'h000, 3'd0, 1'b1);
    chkAddr(10'h380, 3'd7, 1'b1);
    chkAddr(10'h2B5, 3'd2, 1'b1);
    chkAddr(10'h3FF, 3'd4, 1'b1);
    chkAddr(10'h080, 3'd1, 1'b1);
    flip = 1'b0;

    @(negedge clk);
    rstN = 1'b1;
    kPos = 8;

    // R6: no load since reset, outputs remain zero.
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 32'hFFFF_FFFF, "R6");

    // R2, R3: normal order, a load every 8 cycles.
    step(1'b1, 1'b0, 32'h81A5_3CF0, "");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 32'h0, "");
    for (int n = 0; n < 3; n++) begin
      seed = nextRand(seed);
      step(1'b1, 1'b0, seed, "");
      for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 32'h0, "");
    end

    // R2, R4: reversed order.
    step(1'b1, 1'b1, 32'h0180_C3A5, "");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 32'h0, "");
    for (int n = 0; n < 3; n++) begin
      seed = nextRand(seed);
      step(1'b1, 1'b1, seed, "");
      for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 32'h0, "");
    end

    // R5: flip changes every cycle in the middle of each byte.
    for (int n = 0; n < 3; n++) begin
      seed = nextRand(seed);
      step(1'b1, 1'b0, seed, "R5");
      for (int i = 0; i < 7; i++) step(1'b0, (i % 2) == 0, 32'h0, "R5");
    end

    // R6: long gap after a load drains to zero in both settings.
    step(1'b1, 1'b0, 32'hFFFF_FFFF, "");
    for (int i = 0; i < 12; i++) step(1'b0, (i % 3) == 0, 32'h0, "");

    // R7: reloads every 5 cycles and back to back.
    for (int n = 0; n < 4; n++) begin
      seed = nextRand(seed);
      step(1'b1, n[0], seed, "R7");
      for (int i = 0; i < 4; i++) step(1'b0, n[0], 32'h0, "R7");
    end
    for (int n = 0; n < 4; n++) begin
      seed = nextRand(seed);
      step(1'b1, n[1], seed, "R7");
    end
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 32'h0, "");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule